// File: doc/BRIEF.md
# Streaming Block-Program Controller for a Flash Array

This controller sits on the device side of a flash memory and runs a high-throughput factory-programming mode for a single block. The host writes a setup code and then a confirm code to one fixed address. The controller spends a fixed startup window checking the block's write-protect state, the programming-voltage flag and the alignment of that address. If all three pass, it becomes a data pump. Each further write to the same address is taken as one word of a 32-word buffer. When the buffer is full, the controller copies it word by word to the array through a simple write port. An internal offset counter advances for each array word and wraps within the block. The host keeps the same address throughout the mode and polls the status word to learn when the buffer is free again.

In this mode the bus carries no commands. Every read returns the status word. Every write at the fixed address is data, even when its value equals a status-read or suspend code. The mode ends when the host writes to any other address. The controller then drops any partly filled buffer and returns to array-read mode, where reads pass through the array read port.

The state machine has these states:
- `ST_ARRAY`: array read.
- `ST_ARMED`: setup code seen.
- `ST_CHECK`: startup checks.
- `ST_ABORT`: startup failed, status held.
- `ST_LOAD`: buffer accepting words.
- `ST_COMMIT`: buffer copied to the array.
- `ST_PROG`: fixed program/verify delay.

The transitions are:
- ARRAY→ARMED on the setup code.
- ARMED→CHECK on the confirm code at the latched address.
- ARMED→ARRAY on any other write.
- CHECK→LOAD when the checks pass.
- CHECK→ABORT when they fail.
- ABORT→ARRAY on any write.
- LOAD→COMMIT on the 32nd word.
- LOAD→ARRAY on a write to another address.
- COMMIT→PROG after the last array word.
- PROG→LOAD when the delay expires.

Top module: `sfp_ctrl`

## Requirements
- R1: After reset the controller is in array-read mode: `bus_rdata` equals `arr_rdata`, `arr_addr` equals `bus_addr`, and `arr_we` is low.
- R2: A write whose low byte is 0x80 (setup), followed by a write whose low byte is 0xD0 (confirm) at the same address, starts a startup window of CHK_CYC cycles. Throughout that window the status reads 0x00. If the second write is anything else, the controller returns to array-read mode.
- R3: Status bits are: bit 7 ready, bit 4 failure, bit 3 voltage error, bit 1 lock error, bit 0 buffer free. If the block is locked at the end of the window, the status becomes ready, failure and lock error (0x92), and no array write occurs. The status stays readable until the next write, which returns the controller to array-read mode.
- R4: If the voltage flag is low at the end of the window, the failure and voltage-error bits are set (0x98). With a lock fault as well, the status is 0x9A.
- R5: A fixed address whose low five bits are not zero fails the startup with only the failure bit set beside ready (0x90).
- R6: After a passing startup, the status reads 0x01: not ready, buffer free.
- R7: While loading, every write at the fixed address is stored as data. This includes the values 0x0070 and 0x00B0; the latter is a suspend code and has no other effect.
- R8: No array write happens until the 32nd word of a buffer is written. Then `arr_we` is high for exactly 32 consecutive cycles, starting in the cycle after that write, and carries the words in load order.
- R9: Buffer free (bit 0) is low from the 32nd write until PROG_CYC cycles after the last array word. Writes during that time are ignored.
- R10: The array offset starts at the fixed address's offset within the block and rises by one per array word. It continues across buffers and wraps from the block's top back to its first word, with the block bits unchanged.
- R11: A write to any address other than the fixed one while loading ends the mode. Status goes back to ready, reads pass through the array, and any partial buffer is never written.
- R12: Error bits are cleared when a new setup code is accepted, so the status reads 0x80 while armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Host write strobe |
| bus_addr | input | ADDR_W | Host word address |
| bus_wdata | input | DATA_W | Host write data or command code |
| bus_rdata | output | DATA_W | Array data in array-read mode, otherwise the status word |
| blk_locked | input | 1 | Target block is write-protected |
| vpp_ok | input | 1 | Programming voltage is at the required level |
| arr_we | output | 1 | Array word write strobe |
| arr_addr | output | ADDR_W | Array address: write target during commit, host address otherwise |
| arr_wdata | output | DATA_W | Word being written to the array |
| arr_rdata | input | DATA_W | Array read data |

## Verification
The properties assume several things about the inputs:
- Block and offset sizes are powers of two.
- The lock and voltage flags are steady across the startup window.
- The host waits for buffer-free before starting the next buffer.

The stimulus changes those flags only while the controller is in array-read mode. It polls or waits out the exact commit and program delay before loading again. It does make one deliberate write during the busy time, to show that such a write is ignored. All bus writes are driven half a cycle away from the sampling edge and held for one full cycle.

// File: rtl/sfp_pkg.sv
package sfp_pkg;

    typedef enum logic [2:0] {
        ST_ARRAY  = 3'd0,
        ST_ARMED  = 3'd1,
        ST_CHECK  = 3'd2,
        ST_ABORT  = 3'd3,
        ST_LOAD   = 3'd4,
        ST_COMMIT = 3'd5,
        ST_PROG   = 3'd6
    } sfp_state_e;

    localparam logic [7:0] CMD_SETUP   = 8'h80;
    localparam logic [7:0] CMD_CONFIRM = 8'hD0;

    localparam int SR_FREE  = 0;
    localparam int SR_LOCK  = 1;
    localparam int SR_VOLT  = 3;
    localparam int SR_FAIL  = 4;
    localparam int SR_READY = 7;

endpackage

// File: rtl/sfp_wbuf.sv
module sfp_wbuf #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 32,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  ridx,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[widx] <= wdata;
        end
    end

    assign rdata = mem[ridx];

endmodule

// File: rtl/sfp_addr_ctr.sv
module sfp_addr_ctr #(
    parameter int OFF_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [OFF_W-1:0] load_val,
    input  logic             inc,
    output logic [OFF_W-1:0] off
);

    logic [OFF_W-1:0] off_q;

    // Counter width equals the block offset width, so the wrap is implicit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            off_q <= '0;
        end else if (load) begin
            off_q <= load_val;
        end else if (inc) begin
            off_q <= off_q + 1'b1;
        end
    end

    assign off = off_q;

endmodule

// File: rtl/sfp_fsm.sv
module sfp_fsm
    import sfp_pkg::*;
#(
    parameter int ADDR_W    = 22,
    parameter int BUF_WORDS = 32,
    parameter int CHK_CYC   = 8,
    parameter int PROG_CYC  = 16,
    localparam int IDX_W    = $clog2(BUF_WORDS),
    localparam int TMR_MAX  = (CHK_CYC > PROG_CYC) ? CHK_CYC : PROG_CYC,
    localparam int TMR_W    = $clog2(TMR_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        cmd,
    input  logic              blk_locked,
    input  logic              vpp_ok,
    output logic [ADDR_W-1:0] fix_addr,
    output logic [7:0]        sr,
    output logic              rd_status,
    output logic              buf_we,
    output logic [IDX_W-1:0]  buf_widx,
    output logic [IDX_W-1:0]  buf_ridx,
    output logic              ctr_load,
    output logic              arr_we
);

    sfp_state_e        state_q, state_d;
    logic [ADDR_W-1:0] fix_q;
    logic [TMR_W-1:0]  tmr_q;
    logic [IDX_W-1:0]  ld_idx_q;
    logic [IDX_W-1:0]  wr_idx_q;
    logic              err_lock_q, err_volt_q, err_fail_q;

    logic addr_same, misalign, chk_fail, chk_done, prog_done;
    logic setup_hit, last_load, last_wr;

    assign addr_same = (bus_addr == fix_q);
    assign misalign  = |fix_q[IDX_W-1:0];
    assign chk_fail  = blk_locked | ~vpp_ok | misalign;
    assign chk_done  = (tmr_q == TMR_W'(CHK_CYC - 1));
    assign prog_done = (tmr_q == TMR_W'(PROG_CYC - 1));
    assign setup_hit = (state_q == ST_ARRAY) && bus_we && (cmd == CMD_SETUP);
    assign last_load = (ld_idx_q == IDX_W'(BUF_WORDS - 1));
    assign last_wr   = (wr_idx_q == IDX_W'(BUF_WORDS - 1));

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ARRAY: begin
                if (setup_hit) state_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (bus_we) begin
                    state_d = (cmd == CMD_CONFIRM && addr_same) ? ST_CHECK : ST_ARRAY;
                end
            end
            ST_CHECK: begin
                if (chk_done) state_d = chk_fail ? ST_ABORT : ST_LOAD;
            end
            ST_ABORT: begin
                if (bus_we) state_d = ST_ARRAY;
            end
            ST_LOAD: begin
                if (bus_we) begin
                    if (!addr_same)     state_d = ST_ARRAY;
                    else if (last_load) state_d = ST_COMMIT;
                end
            end
            ST_COMMIT: begin
                if (last_wr) state_d = ST_PROG;
            end
            ST_PROG: begin
                if (prog_done) state_d = ST_LOAD;
            end
            default: state_d = ST_ARRAY;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_ARRAY;
        end else begin
            state_q <= state_d;
        end
    end

    // Datapath registers: fixed address, timers, indices, error flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fix_q      <= '0;
            tmr_q      <= '0;
            ld_idx_q   <= '0;
            wr_idx_q   <= '0;
            err_lock_q <= 1'b0;
            err_volt_q <= 1'b0;
            err_fail_q <= 1'b0;
        end else begin
            if (setup_hit) begin
                fix_q      <= bus_addr;
                err_lock_q <= 1'b0;
                err_volt_q <= 1'b0;
                err_fail_q <= 1'b0;
            end
            if (state_q == ST_CHECK && chk_done) begin
                err_lock_q <= blk_locked;
                err_volt_q <= ~vpp_ok;
                err_fail_q <= chk_fail;
            end

            if (state_q != state_d) begin
                tmr_q <= '0;
            end else if (state_q == ST_CHECK || state_q == ST_PROG) begin
                tmr_q <= tmr_q + 1'b1;
            end

            if (state_q != ST_LOAD) begin
                ld_idx_q <= '0;
            end else if (bus_we && addr_same) begin
                ld_idx_q <= ld_idx_q + 1'b1;
            end

            if (state_q == ST_COMMIT) begin
                wr_idx_q <= wr_idx_q + 1'b1;
            end else begin
                wr_idx_q <= '0;
            end
        end
    end

    // Outputs
    always_comb begin
        sr           = '0;
        sr[SR_READY] = (state_q == ST_ARRAY) || (state_q == ST_ARMED) || (state_q == ST_ABORT);
        sr[SR_FAIL]  = err_fail_q;
        sr[SR_VOLT]  = err_volt_q;
        sr[SR_LOCK]  = err_lock_q;
        sr[SR_FREE]  = (state_q == ST_LOAD);
        rd_status    = (state_q != ST_ARRAY);
        buf_we       = (state_q == ST_LOAD) && bus_we && addr_same;
        buf_widx     = ld_idx_q;
        buf_ridx     = wr_idx_q;
        ctr_load     = (state_q == ST_CHECK);
        arr_we       = (state_q == ST_COMMIT);
        fix_addr     = fix_q;
    end

endmodule

// File: rtl/sfp_ctrl.sv
module sfp_ctrl #(
    parameter int ADDR_W    = 22,
    parameter int DATA_W    = 16,
    parameter int BLK_WORDS = 65536,
    parameter int BUF_WORDS = 32,
    parameter int CHK_CYC   = 8,
    parameter int PROG_CYC  = 16,
    localparam int OFF_W    = $clog2(BLK_WORDS),
    localparam int IDX_W    = $clog2(BUF_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              blk_locked,
    input  logic              vpp_ok,
    output logic              arr_we,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [DATA_W-1:0] arr_wdata,
    input  logic [DATA_W-1:0] arr_rdata
);

    logic [ADDR_W-1:0] fix_addr;
    logic [7:0]        sr;
    logic              rd_status;
    logic              buf_we;
    logic [IDX_W-1:0]  buf_widx, buf_ridx;
    logic              ctr_load;
    logic [OFF_W-1:0]  off;

    sfp_fsm #(
        .ADDR_W   (ADDR_W),
        .BUF_WORDS(BUF_WORDS),
        .CHK_CYC  (CHK_CYC),
        .PROG_CYC (PROG_CYC)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .cmd       (bus_wdata[7:0]),
        .blk_locked(blk_locked),
        .vpp_ok    (vpp_ok),
        .fix_addr  (fix_addr),
        .sr        (sr),
        .rd_status (rd_status),
        .buf_we    (buf_we),
        .buf_widx  (buf_widx),
        .buf_ridx  (buf_ridx),
        .ctr_load  (ctr_load),
        .arr_we    (arr_we)
    );

    sfp_wbuf #(
        .DATA_W(DATA_W),
        .DEPTH (BUF_WORDS)
    ) u_wbuf (
        .clk  (clk),
        .we   (buf_we),
        .widx (buf_widx),
        .wdata(bus_wdata),
        .ridx (buf_ridx),
        .rdata(arr_wdata)
    );

    sfp_addr_ctr #(
        .OFF_W(OFF_W)
    ) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (ctr_load),
        .load_val(fix_addr[OFF_W-1:0]),
        .inc     (arr_we),
        .off     (off)
    );

    assign arr_addr  = arr_we ? {fix_addr[ADDR_W-1:OFF_W], off} : bus_addr;
    assign bus_rdata = rd_status ? DATA_W'(sr) : arr_rdata;

endmodule

// File: rtl/sfp_ctrl_chk.sv
module sfp_ctrl_chk #(
    parameter int ADDR_W    = 22,
    parameter int BLK_WORDS = 65536,
    parameter int BUF_WORDS = 32,
    localparam int OFF_W    = $clog2(BLK_WORDS),
    localparam int RUN_W    = $clog2(BUF_WORDS) + 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic              arr_we,
    input logic [ADDR_W-1:0] arr_addr,
    input logic [7:0]        rd_lo,
    input logic [7:0]        sr
);

    logic              prev_we_q, prev_bwe_q;
    logic [RUN_W-1:0]  run_q;
    logic [ADDR_W-1:0] prev_addr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_we_q   <= 1'b0;
            prev_bwe_q  <= 1'b0;
            run_q       <= '0;
            prev_addr_q <= '0;
        end else begin
            prev_we_q   <= arr_we;
            prev_bwe_q  <= bus_we;
            run_q       <= arr_we ? run_q + 1'b1 : '0;
            prev_addr_q <= arr_addr;
        end
    end

    // R8: every burst of array writes is exactly one buffer long
    a_r8_full_burst: assert property (@(posedge clk) disable iff (!rst_n)
        (!arr_we && prev_we_q) |-> (run_q == RUN_W'(BUF_WORDS)));

    // R8: a burst begins only right after a host write
    a_r8_burst_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_we && !prev_we_q) |-> prev_bwe_q);

    // R10: offset steps by one inside the block, block bits unchanged
    a_r10_offset_step: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_we && prev_we_q) |->
            (arr_addr[OFF_W-1:0] == OFF_W'(prev_addr_q[OFF_W-1:0] + 1'b1)) &&
            (arr_addr[ADDR_W-1:OFF_W] == prev_addr_q[ADDR_W-1:OFF_W]));

    // R9: while the array is written, status shows busy and buffer not free
    a_r9_busy_status: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> (!rd_lo[0] && !rd_lo[7]));

    // R3: a lock error always comes with the failure bit
    a_r3_lock_fails: assert property (@(posedge clk) disable iff (!rst_n)
        sr[1] |-> sr[4]);

    // R4: a voltage error always comes with the failure bit
    a_r4_volt_fails: assert property (@(posedge clk) disable iff (!rst_n)
        sr[3] |-> sr[4]);

    // R6: buffer free is never shown together with ready
    a_r6_free_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        sr[0] |-> !sr[7]);

endmodule

bind sfp_ctrl sfp_ctrl_chk #(
    .ADDR_W   (ADDR_W),
    .BLK_WORDS(BLK_WORDS),
    .BUF_WORDS(BUF_WORDS)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .bus_we  (bus_we),
    .arr_we  (arr_we),
    .arr_addr(arr_addr),
    .rd_lo   (bus_rdata[7:0]),
    .sr      (sr)
);

// File: tb/sfp_ctrl_tb.sv
`timescale 1ns/1ps
module sfp_ctrl_tb;

    localparam int AW   = 12;
    localparam int DW   = 16;
    localparam int BLK  = 128;
    localparam int BUFW = 32;
    localparam int CHK  = 3;
    localparam int PRG  = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_we = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          blk_locked = 1'b0;
    logic          vpp_ok = 1'b1;
    logic          arr_we;
    logic [AW-1:0] arr_addr;
    logic [DW-1:0] arr_wdata;
    logic [DW-1:0] arr_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [AW-1:0] log_a [256];
    logic [DW-1:0] log_d [256];
    int logcnt = 0;

    always #5 clk = ~clk;

    assign arr_rdata = 16'h5000 | DW'(arr_addr);

    sfp_ctrl #(
        .ADDR_W(AW), .DATA_W(DW), .BLK_WORDS(BLK),
        .BUF_WORDS(BUFW), .CHK_CYC(CHK), .PROG_CYC(PRG)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .blk_locked(blk_locked),
        .vpp_ok(vpp_ok), .arr_we(arr_we), .arr_addr(arr_addr),
        .arr_wdata(arr_wdata), .arr_rdata(arr_rdata)
    );

    always @(negedge clk) begin
        if (rst_n && arr_we && logcnt < 256) begin
            log_a[logcnt] = arr_addr;
            log_d[logcnt] = arr_wdata;
            logcnt = logcnt + 1;
        end
    end

    // {lock, vpp_ok, fixed address, expected status}
    localparam int VW = 22;
    localparam logic [VW-1:0] VEC [5] = '{
        {1'b1, 1'b1, 12'h3E0, 8'h92},   // R3 lock fault
        {1'b0, 1'b1, 12'h3E0, 8'h01},   // R6 pass
        {1'b0, 1'b0, 12'h3E0, 8'h98},   // R4 voltage fault
        {1'b1, 1'b0, 12'h3E0, 8'h9A},   // R4 both faults
        {1'b0, 1'b1, 12'h3E5, 8'h90}    // R5 misaligned
    };

    task automatic chk(input logic [DW-1:0] act, input logic [DW-1:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    function automatic logic [DW-1:0] word1(input int i);
        if (i == 3) return 16'h0070;
        if (i == 4) return 16'h00B0;
        return 16'h1000 + DW'(i);
    endfunction

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        bus_addr = 12'h123;
        @(negedge clk);

        // R1 reset state
        chk(bus_rdata, 16'h5123, "R1 read passthrough");
        chk(DW'(arr_addr), 16'h0123, "R1 addr passthrough");
        chk(DW'(arr_we), 16'h0000, "R1 no array write");

        // Startup vector table
        for (int v = 0; v < 5; v++) begin
            logic [AW-1:0] a;
            a          = VEC[v][19:8];
            blk_locked = VEC[v][21];
            vpp_ok     = VEC[v][20];
            wr(a, 16'h0080);
            chk(bus_rdata, 16'h0080, "R12 armed status cleared");
            wr(a, 16'h00D0);
            chk(bus_rdata, 16'h0000, "R2 status during startup");
            repeat (CHK) @(negedge clk);
            chk(bus_rdata, DW'(VEC[v][7:0]), "R3/R4/R5/R6 startup result");
            wr(12'h000, 16'hFFFF);
            chk(bus_rdata, 16'h5000, "R3 R11 back to array read");
        end
        chk(DW'(logcnt), 16'd0, "R3 no array write on failures");

        // R2: wrong second command aborts
        blk_locked = 1'b0;
        vpp_ok     = 1'b1;
        wr(12'h3E0, 16'h0080);
        wr(12'h3E0, 16'h0070);
        chk(bus_rdata, 16'h53E0, "R2 non-confirm returns to array");

        // Streaming: enter mode at offset 0x60 of a 128-word block
        wr(12'h3E0, 16'h0080);
        wr(12'h3E0, 16'h00D0);
        repeat (CHK) @(negedge clk);
        chk(bus_rdata, 16'h0001, "R6 loading status");
        for (int i = 0; i < 31; i++) wr(12'h3E0, word1(i));
        chk(bus_rdata, 16'h0001, "R7 command codes taken as data");
        chk(DW'(logcnt), 16'd0, "R8 nothing written before full buffer");
        wr(12'h3E0, word1(31));
        chk(bus_rdata, 16'h0000, "R9 busy right after last word");
        wr(12'h000, 16'hDEAD);        // ignored while busy
        repeat (34) @(negedge clk);
        chk(bus_rdata, 16'h0000, "R9 still busy in program delay");
        @(negedge clk);
        chk(bus_rdata, 16'h0001, "R9 buffer free again");
        chk(DW'(logcnt), 16'd32, "R8 exactly 32 array words");
        for (int i = 0; i < 32; i++) begin
            chk(DW'(log_a[i]), DW'(12'h380 | ((12'h060 + AW'(i)) & 12'h07F)), "R10 first buffer address");
            chk(log_d[i], word1(i), "R7 R8 first buffer data");
        end

        // Second buffer wraps to the block start
        for (int i = 0; i < 32; i++) wr(12'h3E0, 16'h2000 + DW'(i));
        repeat (36) @(negedge clk);
        chk(bus_rdata, 16'h0001, "R9 free after second buffer");
        chk(DW'(logcnt), 16'd64, "R8 second buffer count");
        for (int i = 0; i < 32; i++) begin
            chk(DW'(log_a[32 + i]), DW'(12'h380 + AW'(i)), "R10 wrapped address");
            chk(log_d[32 + i], 16'h2000 + DW'(i), "R10 wrapped data");
        end

        // R11: partial buffer then exit
        for (int i = 0; i < 5; i++) wr(12'h3E0, 16'h3000 + DW'(i));
        wr(12'h000, 16'h1234);
        chk(bus_rdata, 16'h5000, "R11 exit to array read");
        repeat (40) @(negedge clk);
        chk(DW'(logcnt), 16'd64, "R11 partial buffer discarded");
        chk(DW'(arr_we), 16'h0000, "R11 no write after exit");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule